// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running watchdog clocked from a 32.768 kHz low-speed clock. Once enabled, a counter advances on every clock and overflows after one of four selectable periods (about 125 ms, 500 ms, 2 s or 8 s). If software does not service the watchdog, the first overflow raises a non-maskable interrupt flag. If the following overflow also arrives without service, the block escalates. The escalation is either a fixed-length system reset request or a sticky host notification level, and a mode input selects which.

Software services the watchdog by writing a two-byte key, 0x5A followed by 0xA5. This zeroes the counter and returns the escalation state to idle. A run control input halts the counter. The period can only be changed while the counter is halted. The oscillator and the reset distribution network are outside this block.

Top module: `twostage_wdog`

## Requirements
- R1: While rst_n is low, nmi_o, rst_req_o and host_note_o are 0 and per_o equals the reset period code (0 by default).
- R2: Period code s on per_o (0..3) sets the overflow interval to 2^(BASE_LOG2 + 2*s) counted clocks. The default BASE_LOG2 of 12 gives 4096, 16384, 65536 and 262144 clocks. With the counter zeroed, the first overflow happens on the edge that ends the interval.
- R3: The first overflow after reset or after a service sets nmi_o on that edge. nmi_o then stays at 1 until a valid service.
- R4: With esc_mode = 0, an overflow while nmi_o is already 1 drives rst_req_o high for exactly RST_CYC clocks (default 32), starting on that edge.
- R5: With esc_mode = 1, an overflow while nmi_o is 1 sets host_note_o instead of pulsing rst_req_o. host_note_o stays at 1 until a notify_clr pulse clears it.
- R6: key_wr with key_data 0x5A, followed by the next key_wr with key_data 0xA5, zeroes the counter and clears nmi_o on the edge of the second write. The next overflow then comes one full interval later, as a first-stage overflow.
- R7: If any key write other than 0xA5 follows 0x5A, the sequence is broken and no service happens. A later 0xA5 alone has no effect.
- R8: While run_en is 0 the counter holds its value and no overflow occurs. When run_en returns to 1, counting resumes from the held value.
- R9: A per_wr strobe loads per_sel into per_o only while run_en is 0. While run_en is 1 the strobe is ignored.
- R10: Each further overflow while nmi_o stays at 1 repeats the second-stage action: a new rst_req_o pulse, or setting host_note_o again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = counter runs, 0 = counter halted |
| per_wr | input | 1 | Period write strobe |
| per_sel | input | 2 | Period code to write |
| esc_mode | input | 1 | Second-stage action: 0 = reset pulse, 1 = host notification |
| key_wr | input | 1 | Service key write strobe |
| key_data | input | 8 | Service key byte |
| notify_clr | input | 1 | Clears host_note_o |
| nmi_o | output | 1 | First-stage non-maskable interrupt flag |
| rst_req_o | output | 1 | Second-stage reset request pulse |
| host_note_o | output | 1 | Second-stage host notification level |
| per_o | output | 2 | Current period code |

## Verification
The bench builds the block with BASE_LOG2 = 4, which gives intervals of 16, 64, 256 and 1024 clocks. It keeps RST_CYC at 32. The short intervals let all four period codes, third overflows and service timing be run to exact cycles within a short run. A 64-clock interval is longer than the 32-clock reset pulse, so the pulse end can be seen cleanly before the next overflow.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h5A;
  localparam logic [7:0] KEY_SECOND = 8'hA5;

  typedef enum logic {KS_IDLE = 1'b0, KS_ARMED = 1'b1} key_st_e;

  // overflow interval in clocks for a period code
  function automatic logic [31:0] wd_limit(input int base_log2, input logic [1:0] sel);
    return 32'd1 << (base_log2 + 2 * int'(sel));
  endfunction
endpackage

// File: rtl/wdog_key.sv
module wdog_key (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       clr_evt
);
  import wdog_pkg::*;

  key_st_e st_q;

  assign clr_evt = key_wr && (st_q == KS_ARMED) && (key_data == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KS_IDLE;
    end else if (key_wr) begin
      st_q <= (key_data == KEY_FIRST) ? KS_ARMED : KS_IDLE;
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int         BASE_LOG2 = 12,
  parameter int         CNT_W     = 18,
  parameter logic [1:0] PER_RST   = 2'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             clr_evt,
  input  logic             per_wr,
  input  logic [1:0]       per_sel,
  output logic [1:0]       per_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] lim_m1;

  assign lim_m1  = CNT_W'(wdog_pkg::wd_limit(BASE_LOG2, per_q) - 32'd1);
  assign ovf_evt = run_en && (cnt_q >= lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= PER_RST;
    end else if (per_wr && !run_en) begin
      per_q <= per_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_evt) begin
      cnt_q <= '0;
    end else if (run_en) begin
      cnt_q <= ovf_evt ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
  parameter int RST_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic clr_evt,
  input  logic esc_mode,
  input  logic notify_clr,
  output logic nmi_q,
  output logic rst_req,
  output logic host_q,
  output logic rst_ld
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic            esc_evt;
  logic [RC_W-1:0] rc_q;

  assign esc_evt = ovf_evt && nmi_q && !clr_evt;
  assign rst_ld  = esc_evt && !esc_mode;
  assign rst_req = (rc_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
    end else if (clr_evt) begin
      nmi_q <= 1'b0;
    end else if (ovf_evt) begin
      nmi_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= '0;
    end else if (rst_ld) begin
      rc_q <= RC_W'(RST_CYC);
    end else if (rc_q != '0) begin
      rc_q <= rc_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q <= 1'b0;
    end else if (esc_evt && esc_mode) begin
      host_q <= 1'b1;
    end else if (notify_clr) begin
      host_q <= 1'b0;
    end
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog #(
  parameter int         BASE_LOG2 = 12,
  parameter int         RST_CYC   = 32,
  parameter logic [1:0] PER_RST   = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       per_wr,
  input  logic [1:0] per_sel,
  input  logic       esc_mode,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       notify_clr,
  output logic       nmi_o,
  output logic       rst_req_o,
  output logic       host_note_o,
  output logic [1:0] per_o
);
  localparam int CNT_W = BASE_LOG2 + 6;

  logic             clr_evt;
  logic             ovf_evt;
  logic             rst_ld;
  logic [CNT_W-1:0] cnt_q;

  wdog_key u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data), .clr_evt(clr_evt)
  );

  wdog_count #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W), .PER_RST(PER_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr_evt(clr_evt),
    .per_wr(per_wr), .per_sel(per_sel), .per_q(per_o), .cnt_q(cnt_q), .ovf_evt(ovf_evt)
  );

  wdog_stage #(.RST_CYC(RST_CYC)) u_stage (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .clr_evt(clr_evt),
    .esc_mode(esc_mode), .notify_clr(notify_clr), .nmi_q(nmi_o),
    .rst_req(rst_req_o), .host_q(host_note_o), .rst_ld(rst_ld)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int RST_CYC = 32,
  parameter int CNT_W   = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             notify_clr,
  input logic             clr_evt,
  input logic             ovf_evt,
  input logic             rst_ld,
  input logic [CNT_W-1:0] cnt_q,
  input logic             nmi_o,
  input logic             rst_req_o,
  input logic             host_note_o,
  input logic [1:0]       per_o
);
  localparam int LW = $clog2(RST_CYC) + 2;
  logic [LW-1:0] hi_len;

  // clocks the reset request has been high since its last load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else if (rst_ld) hi_len <= '0;
    else if (rst_req_o) hi_len <= hi_len + 1'b1;
  end

  assert_nmi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !clr_evt) |=> nmi_o);
  assert_nmi_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(ovf_evt));
  assert_rst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> (hi_len == LW'(RST_CYC)));
  assert_rst_after_nmi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(nmi_o));
  assert_host_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_note_o && !notify_clr) |=> host_note_o);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (cnt_q == '0 && !nmi_o));
  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr_evt) |=> $stable(cnt_q));
  assert_per_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(per_o));
endmodule

bind twostage_wdog wdog_chk #(.RST_CYC(RST_CYC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .notify_clr(notify_clr),
  .clr_evt(clr_evt), .ovf_evt(ovf_evt), .rst_ld(rst_ld), .cnt_q(cnt_q),
  .nmi_o(nmi_o), .rst_req_o(rst_req_o), .host_note_o(host_note_o), .per_o(per_o)
);

// File: tb/sim_twostage_wdog.sv
`timescale 1ns/1ps
module sim_twostage_wdog;
  localparam int B = 4;
  localparam int RC = 32;
  localparam int SIG_NMI = 0, SIG_RST = 1, SIG_HOST = 2, SIG_PER = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, per_wr = 1'b0, esc_mode = 1'b0, key_wr = 1'b0, notify_clr = 1'b0;
  logic [1:0] per_sel = 2'd0;
  logic [7:0] key_data = 8'h00;
  logic nmi_o, rst_req_o, host_note_o;
  logic [1:0] per_o;

  always #2 clk = ~clk;

  twostage_wdog #(.BASE_LOG2(B), .RST_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .per_wr(per_wr), .per_sel(per_sel),
    .esc_mode(esc_mode), .key_wr(key_wr), .key_data(key_data), .notify_clr(notify_clr),
    .nmi_o(nmi_o), .rst_req_o(rst_req_o), .host_note_o(host_note_o), .per_o(per_o)
  );

  typedef struct {
    int         at;
    int         sig;
    logic [1:0] val;
    string      req;
  } exp_t;

  exp_t sbq[$];
  int cyc = 0;
  int total = 0;
  int n_run = 0;
  int n_fail = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  function automatic logic [1:0] peek(input int sig);
    case (sig)
      SIG_NMI:  return {1'b0, nmi_o};
      SIG_RST:  return {1'b0, rst_req_o};
      SIG_HOST: return {1'b0, host_note_o};
      default:  return per_o;
    endcase
  endfunction

  // monitor: pop and compare items due this cycle; also the watchdog
  always @(negedge clk) begin
    total <= total + 1;
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        n_run = n_run + 1;
        if (peek(sbq[i].sig) !== sbq[i].val) begin
          n_fail = n_fail + 1;
          $display("FAIL %s sig%0d cycle %0d: actual %0d expected %0d",
                   sbq[i].req, sbq[i].sig, cyc, peek(sbq[i].sig), sbq[i].val);
        end
        sbq.delete(i);
      end
    end
    if (total > 60000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic expect_at(input int c, input int sig, input logic [1:0] v, input string r);
    exp_t e;
    e.at = c; e.sig = sig; e.val = v; e.req = r;
    sbq.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic start(input logic [1:0] sel, input logic mode, output int t0);
    rst_n = 1'b0; run_en = 1'b0; per_wr = 1'b0; key_wr = 1'b0; notify_clr = 1'b0;
    esc_mode = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    per_wr = 1'b1; per_sel = sel;
    @(negedge clk);
    per_wr = 1'b0; run_en = 1'b1;
    t0 = cyc;
  endtask

  task automatic key_at(input int c, input logic [7:0] v);
    wait_until(c);
    key_wr = 1'b1; key_data = v;
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  initial begin
    int t0;
    // R1: reset state
    repeat (2) @(negedge clk);
    expect_at(0, SIG_NMI, 2'd0, "R1");
    expect_at(0, SIG_RST, 2'd0, "R1");
    expect_at(0, SIG_HOST, 2'd0, "R1");
    expect_at(0, SIG_PER, 2'd0, "R1");
    repeat (2) @(negedge clk);
    drain();

    // R2 / R3: every period code, first overflow sets the flag
    for (int s = 0; s < 4; s++) begin
      int p;
      p = 16 << (2 * s);
      start(2'(s), 1'b0, t0);
      expect_at(t0 + 1, SIG_PER, 2'(s), "R2");
      expect_at(t0 + p - 1, SIG_NMI, 2'd0, "R2");
      expect_at(t0 + p, SIG_NMI, 2'd1, "R3");
      expect_at(t0 + p + 3, SIG_NMI, 2'd1, "R3");
      wait_until(t0 + p + 4);
      drain();
    end

    // R4 / R10: reset pulse, interval 64
    start(2'd1, 1'b0, t0);
    expect_at(t0 + 64, SIG_NMI, 2'd1, "R3");
    expect_at(t0 + 127, SIG_RST, 2'd0, "R4");
    expect_at(t0 + 128, SIG_RST, 2'd1, "R4");
    expect_at(t0 + 159, SIG_RST, 2'd1, "R4");
    expect_at(t0 + 160, SIG_RST, 2'd0, "R4");
    expect_at(t0 + 130, SIG_HOST, 2'd0, "R4");
    expect_at(t0 + 191, SIG_RST, 2'd0, "R10");
    expect_at(t0 + 192, SIG_RST, 2'd1, "R10");
    expect_at(t0 + 224, SIG_RST, 2'd0, "R10");
    wait_until(t0 + 226);
    drain();

    // R5 / R10: host notification, interval 16
    start(2'd0, 1'b1, t0);
    expect_at(t0 + 16, SIG_NMI, 2'd1, "R3");
    expect_at(t0 + 31, SIG_HOST, 2'd0, "R5");
    expect_at(t0 + 32, SIG_HOST, 2'd1, "R5");
    expect_at(t0 + 33, SIG_RST, 2'd0, "R5");
    expect_at(t0 + 40, SIG_HOST, 2'd1, "R5");
    expect_at(t0 + 41, SIG_HOST, 2'd0, "R5");
    expect_at(t0 + 48, SIG_HOST, 2'd1, "R10");
    wait_until(t0 + 40);
    notify_clr = 1'b1;
    @(negedge clk);
    notify_clr = 1'b0;
    wait_until(t0 + 50);
    drain();

    // R6: valid service, interval 64
    start(2'd1, 1'b0, t0);
    expect_at(t0 + 64, SIG_NMI, 2'd0, "R6");
    expect_at(t0 + 95, SIG_NMI, 2'd0, "R6");
    expect_at(t0 + 96, SIG_NMI, 2'd1, "R6");
    expect_at(t0 + 101, SIG_NMI, 2'd1, "R6");
    expect_at(t0 + 102, SIG_NMI, 2'd0, "R6");
    expect_at(t0 + 166, SIG_NMI, 2'd1, "R6");
    expect_at(t0 + 167, SIG_RST, 2'd0, "R6");
    key_at(t0 + 30, 8'h5A);
    key_at(t0 + 31, 8'hA5);
    key_at(t0 + 100, 8'h5A);
    key_at(t0 + 101, 8'hA5);
    wait_until(t0 + 170);
    drain();

    // R7: broken sequence, interval 16
    start(2'd0, 1'b0, t0);
    expect_at(t0 + 15, SIG_NMI, 2'd0, "R7");
    expect_at(t0 + 16, SIG_NMI, 2'd1, "R7");
    key_at(t0 + 4, 8'h5A);
    key_at(t0 + 5, 8'h00);
    key_at(t0 + 6, 8'hA5);
    key_at(t0 + 10, 8'hA5);
    wait_until(t0 + 18);
    drain();

    // R8: halt holds the count, interval 16
    start(2'd0, 1'b0, t0);
    expect_at(t0 + 40, SIG_NMI, 2'd0, "R8");
    expect_at(t0 + 55, SIG_NMI, 2'd0, "R8");
    expect_at(t0 + 56, SIG_NMI, 2'd1, "R8");
    wait_until(t0 + 5);
    run_en = 1'b0;
    wait_until(t0 + 45);
    run_en = 1'b1;
    wait_until(t0 + 58);
    drain();

    // R9: period write locked while running
    start(2'd0, 1'b0, t0);
    expect_at(t0 + 5, SIG_PER, 2'd0, "R9");
    expect_at(t0 + 16, SIG_NMI, 2'd1, "R9");
    expect_at(t0 + 22, SIG_PER, 2'd2, "R9");
    wait_until(t0 + 3);
    per_wr = 1'b1; per_sel = 2'd3;
    @(negedge clk);
    per_wr = 1'b0;
    wait_until(t0 + 20);
    run_en = 1'b0;
    @(negedge clk);
    per_wr = 1'b1; per_sel = 2'd2;
    @(negedge clk);
    per_wr = 1'b0;
    wait_until(t0 + 24);
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule